// File: doc/BRIEF.md
# Reduced-Width Wakeup Tag Broadcaster

This block sits between the result ports of the functional units and the wakeup taglines of an issue queue. Each cycle up to four completing destination tags arrive, one per result lane. In full-width mode every lane drives its own tagline in the same cycle. In reduced mode only the odd taglines (1 and 3) are live, and the comparators on taglines 0 and 2 are treated as powered down. Tags that find no free live tagline wait in a small first-in first-out overflow buffer and go out in a later cycle.

The set of live taglines is held in a register, so the match-line precharge logic knows it one full cycle before any tag is driven. A mode request takes effect at the next clock edge. A return to full width is held back until the overflow buffer is empty. The stall output is registered and is raised early enough that the buffer can never overflow, even when four tags arrive at once.

Top module: `wakeup_tag_narrower`

## Requirements
- R1: While reset is active, and right after it, the live mask is 4'b1111, stall is low, and no tagline is valid.
- R2: In full-width mode, an accepted tag on result lane i appears on tagline i in the same cycle. Tagline valid equals the accepted lane mask.
- R3: In reduced mode, the live mask is 4'b1010 (taglines 1 and 3). No tag is ever valid on a tagline whose live bit is 0.
- R4: In reduced mode, the broadcast order is: buffered tags first, oldest first, then the new tags of the cycle in ascending lane order. The earlier tag of a cycle takes tagline 1 and the later one takes tagline 3. Any tag left over is appended to the buffer in the same order.
- R5: A reduced-mode request sampled at a clock edge makes the live mask 4'b1010 from that edge on. The live mask never changes except at a clock edge.
- R6: When full width is requested, the live mask returns to 4'b1111 only at the first edge after which the overflow buffer is empty.
- R7: The stall output rises at the edge after which the buffer holds more than DEPTH-2 tags in reduced mode, and it is low otherwise. While stall is high, the result valids are ignored.
- R8: Every accepted tag is broadcast exactly once. No tag is dropped, duplicated or invented, and the 4-entry buffer never overflows.
- R9: In reduced mode, buffered tags use the live taglines even in cycles with no new results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| narrow_req_i | input | 1 | Request reduced-width broadcast |
| res_valid_i | input | LANES | Result tag valid per lane |
| res_tag_i | input | LANES*TAG_W | Result tags, lane i at bits [i*TAG_W +: TAG_W] |
| line_valid_o | output | LANES | Tag valid per tagline |
| line_tag_o | output | LANES*TAG_W | Tag per tagline, tagline i at bits [i*TAG_W +: TAG_W] |
| line_live_o | output | LANES | Registered live-tagline mask (1 = comparators powered) |
| stall_o | output | 1 | Functional units must hold results this cycle |

## Verification
The bench sends four-tag bursts into a reduced-width broadcaster until the buffer reaches its stall threshold. A stall raised one cycle late would let a burst overflow the buffer, and a missing stall would drop tags. Both show up as scoreboard mismatches or as tags that never arrive. Results driven during a stall must vanish: a design that accepts them broadcasts tags the scoreboard never expected. A full-width request made while the buffer still holds tags must keep the odd-only mask until the buffer drains; releasing it early would strand or misorder buffered tags. A long random phase mixes mode flips with sparse and dense lane masks, which exposes ordering mistakes between buffered and new tags.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  typedef enum logic {WIDTH_FULL = 1'b0, WIDTH_NARROW = 1'b1} width_e;

  function automatic int min_int(int a, int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/tbw_compact.sv
module tbw_compact #(
  parameter int LANES = 4,
  parameter int TAG_W = 7,
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]            valid_i,
  input  logic [LANES-1:0][TAG_W-1:0] tag_i,
  output logic [LANES-1:0][TAG_W-1:0] tag_o,
  output logic [NW-1:0]               num_o
);
  // pack valid lanes towards index 0, keeping lane order
  always_comb begin
    int n;
    n = 0;
    tag_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (valid_i[i]) begin
        for (int j = 0; j < LANES; j++) begin
          if (j == n) tag_o[j] = tag_i[i];
        end
        n = n + 1;
      end
    end
    num_o = NW'(n);
  end
endmodule

// File: rtl/tbw_ovf_fifo.sv
module tbw_ovf_fifo #(
  parameter int DEPTH    = 4,
  parameter int TAG_W    = 7,
  parameter int PUSH_MAX = 4,
  parameter int POP_MAX  = 2,
  localparam int PW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int PNW  = $clog2(PUSH_MAX + 1),
  localparam int QNW  = $clog2(POP_MAX + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [QNW-1:0]                pop_n_i,
  input  logic [PNW-1:0]                push_n_i,
  input  logic [PUSH_MAX-1:0][TAG_W-1:0] push_tag_i,
  output logic [POP_MAX-1:0][TAG_W-1:0] head_o,
  output logic [CNTW-1:0]               cnt_o,
  output logic [CNTW-1:0]               cnt_next_o
);
  logic [DEPTH-1:0][TAG_W-1:0] mem_q;
  logic [PW-1:0]               rd_q;
  logic [CNTW-1:0]             cnt_q;

  assign cnt_o      = cnt_q;
  assign cnt_next_o = CNTW'(int'(cnt_q) + int'(push_n_i) - int'(pop_n_i));

  for (genvar k = 0; k < POP_MAX; k++) begin : g_head
    assign head_o[k] = mem_q[PW'(int'(rd_q) + k)];
  end

  // writes land behind the live entries; popped slots may be reused
  always_ff @(posedge clk_i) begin
    for (int m = 0; m < PUSH_MAX; m++) begin
      if (m < int'(push_n_i)) mem_q[PW'(int'(rd_q) + int'(cnt_q) + m)] <= push_tag_i[m];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= PW'(int'(rd_q) + int'(pop_n_i));
      cnt_q <= cnt_next_o;
    end
  end

  p_pop_avail_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_n_i) <= int'(cnt_q));
  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) + int'(push_n_i) - int'(pop_n_i) <= DEPTH);
endmodule

// File: rtl/tbw_mode_ctrl.sv
module tbw_mode_ctrl
  import tbw_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 4,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            narrow_req_i,
  input  logic [CNTW-1:0] cnt_next_i,
  output logic            narrow_o,
  output logic [LANES-1:0] live_o,
  output logic            stall_o
);
  localparam int LIVE_N   = LANES / 2;
  // worst-case growth per cycle is LANES-LIVE_N tags
  localparam int STALL_AT = DEPTH - (LANES - LIVE_N);

  width_e state_q, state_d;
  logic   stall_d;

  always_comb begin
    state_d = (narrow_req_i || cnt_next_i != '0) ? WIDTH_NARROW : WIDTH_FULL;
    stall_d = (state_d == WIDTH_NARROW) && (int'(cnt_next_i) > STALL_AT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WIDTH_FULL;
      stall_q_reg: stall_o <= 1'b0;
    end else begin
      state_q <= state_d;
      stall_o <= stall_d;
    end
  end

  assign narrow_o = (state_q == WIDTH_NARROW);

  for (genvar l = 0; l < LANES; l++) begin : g_live
    localparam bit ODD = (l % 2) == 1;
    assign live_o[l] = ODD | ~narrow_o;
  end

  p_enter_narrow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_req_i |=> narrow_o);
  p_stall_narrow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> narrow_o);
endmodule

// File: rtl/wakeup_tag_narrower.sv
module wakeup_tag_narrower
  import tbw_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 4,
  parameter int TAG_W = 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   narrow_req_i,
  input  logic [LANES-1:0]       res_valid_i,
  input  logic [LANES*TAG_W-1:0] res_tag_i,
  output logic [LANES-1:0]       line_valid_o,
  output logic [LANES*TAG_W-1:0] line_tag_o,
  output logic [LANES-1:0]       line_live_o,
  output logic                   stall_o
);
  localparam int LIVE_N = LANES / 2;
  localparam int NW     = $clog2(LANES + 1);
  localparam int QNW    = $clog2(LIVE_N + 1);
  localparam int CNTW   = $clog2(DEPTH + 1);

  logic [LANES-1:0][TAG_W-1:0]  res_tag_v, new_tag, push_tag, line_tag_v;
  logic [LANES-1:0]             acc_valid;
  logic [NW-1:0]                new_n, push_n;
  logic [QNW-1:0]               pop_n;
  logic [LIVE_N-1:0][TAG_W-1:0] head, slot_tag;
  logic [LIVE_N-1:0]            slot_valid;
  logic [CNTW-1:0]              fifo_cnt, fifo_cnt_next;
  logic                         narrow;

  assign res_tag_v  = res_tag_i;
  assign line_tag_o = line_tag_v;
  assign acc_valid  = stall_o ? '0 : res_valid_i;

  tbw_compact #(.LANES(LANES), .TAG_W(TAG_W)) u_compact (
    .valid_i (acc_valid),
    .tag_i   (res_tag_v),
    .tag_o   (new_tag),
    .num_o   (new_n)
  );

  tbw_ovf_fifo #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .PUSH_MAX(LANES), .POP_MAX(LIVE_N)
  ) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_n_i    (pop_n),
    .push_n_i   (push_n),
    .push_tag_i (push_tag),
    .head_o     (head),
    .cnt_o      (fifo_cnt),
    .cnt_next_o (fifo_cnt_next)
  );

  tbw_mode_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .narrow_req_i (narrow_req_i),
    .cnt_next_i   (fifo_cnt_next),
    .narrow_o     (narrow),
    .live_o       (line_live_o),
    .stall_o      (stall_o)
  );

  // reduced-mode slot fill: buffered tags first, then new tags; rest spills
  always_comb begin
    int n_new, n_pop, n_free, n_push;
    n_new  = int'(new_n);
    n_pop  = narrow ? min_int(int'(fifo_cnt), LIVE_N) : 0;
    n_free = LIVE_N - n_pop;
    n_push = (narrow && n_new > n_free) ? n_new - n_free : 0;
    for (int k = 0; k < LIVE_N; k++) begin
      slot_valid[k] = 1'b0;
      slot_tag[k]   = '0;
      if (k < n_pop) begin
        slot_valid[k] = 1'b1;
        slot_tag[k]   = head[k];
      end else begin
        for (int j = 0; j < LANES; j++) begin
          if (j == k - n_pop && j < n_new) begin
            slot_valid[k] = 1'b1;
            slot_tag[k]   = new_tag[j];
          end
        end
      end
    end
    for (int m = 0; m < LANES; m++) begin
      push_tag[m] = '0;
      for (int j = 0; j < LANES; j++) begin
        if (j == m + n_free) push_tag[m] = new_tag[j];
      end
    end
    pop_n  = QNW'(n_pop);
    push_n = NW'(n_push);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_line
    if (l % 2 == 1) begin : g_odd
      assign line_valid_o[l] = narrow ? slot_valid[l/2] : acc_valid[l];
      assign line_tag_v[l]   = !line_valid_o[l] ? '0 :
                               (narrow ? slot_tag[l/2] : res_tag_v[l]);
    end else begin : g_even
      assign line_valid_o[l] = ~narrow & acc_valid[l];
      assign line_tag_v[l]   = line_valid_o[l] ? res_tag_v[l] : '0;
    end
  end

  p_live_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_o & ~line_live_o) == '0);
  p_full_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_live_o == '1) |-> (line_valid_o == res_valid_i));
  p_full_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_live_o == '1) |-> (fifo_cnt == '0));
  p_drain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_live_o != '1 && fifo_cnt != '0) |-> line_valid_o[1]);
  p_stall_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (push_n == '0 && line_valid_o == '0 || fifo_cnt != '0));
endmodule

// File: tb/tb_wakeup_tag_narrower.sv
module tb_wakeup_tag_narrower;
  localparam int LANES = 4;
  localparam int TAG_W = 7;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   narrow_req;
  logic [LANES-1:0]       res_valid;
  logic [LANES*TAG_W-1:0] res_tag;
  logic [LANES-1:0]       line_valid, line_live;
  logic [LANES*TAG_W-1:0] line_tag;
  logic                   stall;

  wakeup_tag_narrower #(.LANES(LANES), .DEPTH(4), .TAG_W(TAG_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .narrow_req_i(narrow_req),
    .res_valid_i(res_valid), .res_tag_i(res_tag),
    .line_valid_o(line_valid), .line_tag_o(line_tag),
    .line_live_o(line_live), .stall_o(stall)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit run = 1'b0;
  bit finished = 1'b0;
  logic [TAG_W-1:0] exp_q[$];
  logic [TAG_W-1:0] next_tag = '0;
  bit m_narrow = 1'b0;
  bit m_stall = 1'b0;
  int m_cnt = 0;
  bit m_return = 1'b0;
  bit cur_narrow = 1'b0;
  logic [LANES-1:0] cur_acc = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, checks registered outputs against model
  task automatic cycle(input bit req, input logic [LANES-1:0] vmask);
    int acc;
    @(posedge clk);
    #1;
    chk(line_live == (m_narrow ? 4'b1010 : 4'b1111), m_return ? "R6" : "R5",
        int'(line_live), m_narrow ? 10 : 15);
    chk(stall == m_stall, "R7", int'(stall), int'(m_stall));
    narrow_req = req;
    res_valid  = vmask;
    for (int i = 0; i < LANES; i++) begin
      if (vmask[i]) begin
        res_tag[i*TAG_W +: TAG_W] = next_tag;
        if (!m_stall) exp_q.push_back(next_tag);
        next_tag = next_tag + 1'b1;
      end else begin
        res_tag[i*TAG_W +: TAG_W] = '0;
      end
    end
    cur_narrow = m_narrow;
    cur_acc    = m_stall ? '0 : vmask;
    acc        = $countones(cur_acc);
    if (m_narrow) m_cnt = (m_cnt + acc - 2 > 0) ? m_cnt + acc - 2 : 0;
    else m_cnt = 0;
    m_return = !req && m_cnt != 0;
    m_narrow = req || m_cnt != 0;
    m_stall  = m_narrow && m_cnt > 2;
  endtask

  // monitor: scoreboard pop in tagline order
  always @(negedge clk) begin
    if (run) begin
      if (!cur_narrow)
        chk(line_valid == cur_acc, "R2", int'(line_valid), int'(cur_acc));
      else
        chk((line_valid & 4'b0101) == 4'b0000, "R3", int'(line_valid), 0);
      for (int l = 0; l < LANES; l++) begin
        if (line_valid[l]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R8", int'(line_tag[l*TAG_W +: TAG_W]), -1);
          end else begin
            logic [TAG_W-1:0] e;
            e = exp_q.pop_front();
            // stalled inputs never enter exp_q (R7); narrow order is R4
            chk(line_tag[l*TAG_W +: TAG_W] == e, cur_narrow ? "R4 R7" : "R2",
                int'(line_tag[l*TAG_W +: TAG_W]), int'(e));
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    narrow_req = 1'b0;
    res_valid  = '0;
    res_tag    = '0;
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state
    chk(line_live == 4'b1111, "R1", int'(line_live), 15);
    chk(stall == 1'b0, "R1", int'(stall), 0);
    chk(line_valid == 4'b0000, "R1", int'(line_valid), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(line_live == 4'b1111 && !stall, "R1", int'(line_live), 15);
    run = 1'b1;

    // R2: full width, several masks
    cycle(1'b0, 4'b1111);
    cycle(1'b0, 4'b0101);
    cycle(1'b0, 4'b1000);
    cycle(1'b0, 4'b0110);
    // R5: request narrow; this cycle still full
    cycle(1'b1, 4'b1111);
    // R3/R4: single tag, then bursts up to the stall threshold (R7)
    cycle(1'b1, 4'b0001);
    cycle(1'b1, 4'b1111);
    cycle(1'b1, 4'b1111);
    cycle(1'b1, 4'b1111);   // stalled: these tags must be ignored (R7)
    cycle(1'b1, 4'b0000);   // R9 drain without input
    cycle(1'b1, 4'b1010);
    cycle(1'b1, 4'b0000);
    // R6: ask for full width while buffer still holds tags
    cycle(1'b1, 4'b1111);
    cycle(1'b1, 4'b1111);
    cycle(1'b0, 4'b0000);
    cycle(1'b0, 4'b0000);
    cycle(1'b0, 4'b0000);
    cycle(1'b0, 4'b1111);
    cycle(1'b0, 4'b0000);

    // random mix of modes and masks
    for (int c = 0; c < 400; c++) begin
      bit rq;
      rq = (($urandom % 8) < 5);
      cycle(rq, 4'($urandom));
    end
    for (int c = 0; c < 6; c++) cycle(1'b0, 4'b0000);
    @(negedge clk);
    #1;
    // R8: every accepted tag has been seen
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
    run = 1'b0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule